// File: doc/BRIEF.md
# MMIO Address to Partition Mapper

This block takes the address of a memory-mapped I/O request and returns the partitionable-endpoint (PE) number that owns it, along with a hit flag. A table of address windows makes the decision. Each window is a base and mask pair with a mapping mode. A window can split its range into equal segments for consecutive PEs. It can instead send the whole range to one PE. Two further modes split the range into segments that each take a PE from a small per-window table, or into 8, 64 or 128 segments counted from a programmable base PE.

Windows are programmed through a single write port while they are disabled. A write that enables a window runs the alignment and legality checks for its mode. A window that fails stays disabled and raises its error bit. Lookups are accepted one per cycle, and each result appears on the registered outputs on the following cycle.

Top module: `mmio_pe_mapper`

## Requirements
- R1: An enabled window hits an address when (addr & mask) == base. After reset no window is enabled and every error bit is 0.
- R2: Segmented mode (mode 0) cuts a window of size 2^k into PE_CNT segments. The PE number is address bits [k-1 : k-log2(PE_CNT)].
- R3: Single mode (mode 1) returns the PE field of the window for every address inside it.
- R4: Remapped mode (mode 2) cuts the window into RMP_SEGS segments. The segment index is address bits [k-1 : k-log2(RMP_SEGS)], and the PE comes from that window's remap table entry for the segment.
- R5: Reduced mode (mode 3) uses the segment-count field as follows: 0 gives 8 segments, 1 gives 64 and 2 gives 128. Segment n returns PE field + n.
- R6: When several enabled windows hit, the lowest-numbered window gives the result.
- R7: A lookup presented in one cycle gives res_valid in the next. On a miss, res_hit is 0 and res_pe is 0. With no lookup, res_valid is 0.
- R8: A single-mode window smaller than 2^SINGLE_MIN_LG bytes (32 MB) is rejected. Its error bit is set and it never hits.
- R9: A reduced-mode window is rejected when its PE field is not a multiple of its segment count, or when the segment-count field is 3.
- R10: A window is rejected when its mask is not a run of ones from the top bit, or when the base has bits set below the mask. It is also rejected when it is too small to hold its mode's segment count.
- R11: While a window is enabled, a configuration write that keeps it enabled is ignored, and so are writes to its remap table.
- R12: A configuration write with cfg_enable=0 stores the fields, disables the window and clears its error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Window configuration write strobe |
| cfg_idx | input | IDX_W | Window being written |
| cfg_enable | input | 1 | Enable requested by the write |
| cfg_mode | input | 2 | 0 segmented, 1 single, 2 remapped, 3 reduced |
| cfg_base | input | ADDR_W | Window base |
| cfg_mask | input | ADDR_W | Window mask |
| cfg_pe | input | PE_W | Single PE, or base PE in reduced mode |
| cfg_segsel | input | 2 | Reduced-mode segment count select |
| rmp_we | input | 1 | Remap table write strobe |
| rmp_idx | input | IDX_W | Window owning the remap entry |
| rmp_seg | input | RS_W | Segment within the remap table |
| rmp_pe | input | PE_W | PE number for that segment |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Lookup address |
| res_valid | output | 1 | Result valid, one cycle after lk_valid |
| res_hit | output | 1 | Some enabled window matched |
| res_pe | output | PE_W | Owning PE, 0 on a miss |
| win_err | output | NWIN | Per-window rejection flag |

## Verification
A wrong segment-size value, a bad shift or a wrong priority chain shows up on res_pe on the cycle after the first lookup that falls in the affected window. For that reason the bench sweeps every segment of a segmented window and of a reduced window. If a legality check stays stuck open or shut, win_err shows it right after the enabling write, and a lookup that hits or misses when it should not confirms it. Locked-window state that was overwritten appears as a changed PE on the next lookup into that window.

// File: rtl/mmio_pe_mapper.sv
module mmio_pe_mapper #(
  parameter int ADDR_W        = 32,
  parameter int NWIN          = 16,
  parameter int PE_CNT        = 256,
  parameter int RMP_SEGS      = 8,
  parameter int SINGLE_MIN_LG = 25,
  localparam int PE_W = $clog2(PE_CNT),
  localparam int IDX_W = $clog2(NWIN),
  localparam int RS_W = $clog2(RMP_SEGS),
  localparam int K_W = $clog2(ADDR_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_enable,
  input  logic [1:0]        cfg_mode,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_mask,
  input  logic [PE_W-1:0]   cfg_pe,
  input  logic [1:0]        cfg_segsel,
  input  logic              rmp_we,
  input  logic [IDX_W-1:0]  rmp_idx,
  input  logic [RS_W-1:0]   rmp_seg,
  input  logic [PE_W-1:0]   rmp_pe,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              res_valid,
  output logic              res_hit,
  output logic [PE_W-1:0]   res_pe,
  output logic [NWIN-1:0]   win_err
);
  localparam logic [1:0] M_SEG = 2'd0, M_ONE = 2'd1, M_RMP = 2'd2, M_RED = 2'd3;

  function automatic logic [K_W-1:0] red_lg(input logic [1:0] s);
    case (s)
      2'd0:    return K_W'(3);
      2'd1:    return K_W'(6);
      default: return K_W'(7);
    endcase
  endfunction

  logic [ADDR_W-1:0] base_q [NWIN];
  logic [ADDR_W-1:0] mask_q [NWIN];
  logic [1:0]        mode_q [NWIN];
  logic [1:0]        sel_q  [NWIN];
  logic [PE_W-1:0]   pe_q   [NWIN];
  logic [K_W-1:0]    k_q    [NWIN];
  logic [PE_W-1:0]   rmp_q  [NWIN][RMP_SEGS];
  logic [NWIN-1:0]   en_q;

  // legality of the incoming configuration
  logic [ADDR_W-1:0] inv;
  logic [K_W-1:0]    k_w, need_lg;
  logic [PE_W-1:0]   red_low;
  logic              cfg_ok;

  assign inv     = ~cfg_mask;
  assign k_w     = K_W'($countones(inv));
  assign red_low = PE_W'((1 << red_lg(cfg_segsel)) - 1);

  always_comb begin
    case (cfg_mode)
      M_SEG:   need_lg = K_W'(PE_W);
      M_ONE:   need_lg = K_W'(SINGLE_MIN_LG);
      M_RMP:   need_lg = K_W'(RS_W);
      default: need_lg = red_lg(cfg_segsel);
    endcase
    cfg_ok = ((inv & (inv + 1'b1)) == '0) && ((cfg_base & inv) == '0) && (k_w >= need_lg);
    if (cfg_mode == M_RED)
      cfg_ok = cfg_ok && (cfg_segsel != 2'd3) && ((cfg_pe & red_low) == '0)
               && (int'(red_lg(cfg_segsel)) <= PE_W);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      win_err <= '0;
      for (int i = 0; i < NWIN; i++) begin
        base_q[i] <= '0; mask_q[i] <= '0; mode_q[i] <= '0;
        sel_q[i]  <= '0; pe_q[i]   <= '0; k_q[i]    <= '0;
        for (int s = 0; s < RMP_SEGS; s++) rmp_q[i][s] <= '0;
      end
    end else begin
      if (cfg_we && (!cfg_enable || !en_q[cfg_idx])) begin
        base_q[cfg_idx]  <= cfg_base;
        mask_q[cfg_idx]  <= cfg_mask;
        mode_q[cfg_idx]  <= cfg_mode;
        sel_q[cfg_idx]   <= cfg_segsel;
        pe_q[cfg_idx]    <= cfg_pe;
        k_q[cfg_idx]     <= k_w;
        en_q[cfg_idx]    <= cfg_enable && cfg_ok;
        win_err[cfg_idx] <= cfg_enable && !cfg_ok;
      end
      if (rmp_we && !en_q[rmp_idx]) rmp_q[rmp_idx][rmp_seg] <= rmp_pe;
    end
  end

  // per-window match and PE
  logic [NWIN-1:0] hit;
  logic [PE_W-1:0] pe_w [NWIN];

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    logic [ADDR_W-1:0] off;
    logic [RS_W-1:0]   ridx;
    assign off    = lk_addr & ~mask_q[i];
    assign hit[i] = en_q[i] && ((lk_addr & mask_q[i]) == base_q[i]);
    assign ridx   = RS_W'(off >> (k_q[i] - K_W'(RS_W)));

    always_comb begin
      case (mode_q[i])
        M_SEG:   pe_w[i] = PE_W'(off >> (k_q[i] - K_W'(PE_W)));
        M_ONE:   pe_w[i] = pe_q[i];
        M_RMP:   pe_w[i] = rmp_q[i][ridx];
        default: pe_w[i] = pe_q[i] + PE_W'(off >> (k_q[i] - red_lg(sel_q[i])));
      endcase
    end

    assert_err_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
      win_err[i] |-> !en_q[i]);
    assert_single_size_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[i] && mode_q[i] == M_ONE) |->
        (mask_q[i][SINGLE_MIN_LG-1:0] == '0 && base_q[i][SINGLE_MIN_LG-1:0] == '0));
    assert_reduced_base_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[i] && mode_q[i] == M_RED) |->
        (sel_q[i] != 2'd3 && (pe_q[i] & PE_W'((1 << red_lg(sel_q[i])) - 1)) == '0));
    assert_mask_shape_R10: assert property (@(posedge clk) disable iff (!rst_n)
      en_q[i] |-> (((~mask_q[i]) & ((~mask_q[i]) + 1'b1)) == '0 && (base_q[i] & ~mask_q[i]) == '0));
    assert_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[i] && $past(en_q[i])) |->
        ($stable(base_q[i]) && $stable(mask_q[i]) && $stable(mode_q[i]) && $stable(pe_q[i])));
  end

  // lowest index wins
  logic            any;
  logic [PE_W-1:0] win_pe;
  always_comb begin
    any = 1'b0;
    win_pe = '0;
    for (int i = NWIN - 1; i >= 0; i--)
      if (hit[i]) begin
        any = 1'b1;
        win_pe = pe_w[i];
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_pe    <= '0;
    end else begin
      res_valid <= lk_valid;
      res_hit   <= lk_valid && any;
      res_pe    <= (lk_valid && any) ? win_pe : '0;
    end
  end

  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid);
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!res_valid && !res_hit));
endmodule

// File: tb/mmio_pe_mapper_tb.sv
`timescale 1ns/1ps
module mmio_pe_mapper_tb;
  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0, cfg_enable = 0;
  logic [3:0]  cfg_idx = 0;
  logic [1:0]  cfg_mode = 0, cfg_segsel = 0;
  logic [31:0] cfg_base = 0, cfg_mask = 0;
  logic [7:0]  cfg_pe = 0;
  logic        rmp_we = 0;
  logic [3:0]  rmp_idx = 0;
  logic [2:0]  rmp_seg = 0;
  logic [7:0]  rmp_pe = 0;
  logic        lk_valid = 0;
  logic [31:0] lk_addr = 0;
  logic        res_valid, res_hit;
  logic [7:0]  res_pe;
  logic [15:0] win_err;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mmio_pe_mapper u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg(input int idx, input bit en, input logic [1:0] mode,
                     input logic [31:0] base, input logic [31:0] mask,
                     input logic [7:0] pe, input logic [1:0] sel);
    cfg_we = 1; cfg_idx = 4'(idx); cfg_enable = en; cfg_mode = mode;
    cfg_base = base; cfg_mask = mask; cfg_pe = pe; cfg_segsel = sel;
    @(posedge clk); #1 cfg_we = 0;
  endtask

  task automatic rmp(input int idx, input int seg, input logic [7:0] pe);
    rmp_we = 1; rmp_idx = 4'(idx); rmp_seg = 3'(seg); rmp_pe = pe;
    @(posedge clk); #1 rmp_we = 0;
  endtask

  task automatic look(input string tag, input logic [31:0] a, input bit hit, input logic [7:0] pe);
    lk_valid = 1; lk_addr = a;
    @(posedge clk); #1 lk_valid = 0;
    chk({tag, " valid"}, 32'(res_valid), 1);
    chk({tag, " hit"}, 32'(res_hit), 32'(hit));
    chk({tag, " pe"}, 32'(res_pe), 32'(hit ? pe : 8'h00));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk("R1 reset err", 32'(win_err), 0);
    chk("R1 reset valid", 32'(res_valid), 0);
    look("R1 empty table", 32'h1000_0000, 0, 0);

    // R2 segmented, 16 MB window, 64 KB segments
    cfg(0, 1, 2'd0, 32'h1000_0000, 32'hFF00_0000, 0, 0);
    for (int n = 0; n < 256; n++)
      look("R2 segmented", 32'h1000_0000 | (n << 16) | ((n * 37) & 16'hFFFF), 1, 8'(n));

    // R3 single, 32 MB
    cfg(1, 1, 2'd1, 32'h4000_0000, 32'hFE00_0000, 8'h5A, 0);
    look("R3 single low", 32'h4000_0000, 1, 8'h5A);
    look("R3 single high", 32'h41FF_FFFC, 1, 8'h5A);
    look("R1 above single", 32'h4200_0000, 0, 0);

    // R8 single too small
    cfg(2, 1, 2'd1, 32'h5000_0000, 32'hFF00_0000, 8'h33, 0);
    chk("R8 err bit", 32'(win_err[2]), 1);
    look("R8 rejected miss", 32'h5000_0100, 0, 0);

    // R4 remapped, 64 KB window, 8 KB segments
    for (int s = 0; s < 8; s++) rmp(3, s, 8'(8'hA0 + s * 3));
    cfg(3, 1, 2'd2, 32'h6000_0000, 32'hFFFF_0000, 0, 0);
    chk("R4 no err", 32'(win_err[3]), 0);
    for (int s = 0; s < 8; s++)
      look("R4 remapped", 32'h6000_0000 | (s << 13) | 32'h123, 1, 8'(8'hA0 + s * 3));

    // R5 reduced, 1 MB window, 64 segments, base PE 128
    cfg(4, 1, 2'd3, 32'h7000_0000, 32'hFFF0_0000, 8'd128, 2'd1);
    for (int n = 0; n < 64; n++)
      look("R5 reduced", 32'h7000_0000 | (n << 14) | ((n * 5) & 14'h3FFF), 1, 8'(128 + n));
    // R5 8-segment variant on a 4 KB window, base PE 16
    cfg(11, 1, 2'd3, 32'h7300_0000, 32'hFFFF_F000, 8'd16, 2'd0);
    for (int n = 0; n < 8; n++)
      look("R5 reduced8", 32'h7300_0000 | (n << 9), 1, 8'(16 + n));

    // R9 rejections
    cfg(5, 1, 2'd3, 32'h7100_0000, 32'hFFF0_0000, 8'd100, 2'd1);
    chk("R9 misaligned base pe", 32'(win_err[5]), 1);
    look("R9 misaligned miss", 32'h7100_0000, 0, 0);
    cfg(6, 1, 2'd3, 32'h7200_0000, 32'hFFF0_0000, 8'd0, 2'd3);
    chk("R9 bad segsel", 32'(win_err[6]), 1);

    // R10 rejections
    cfg(8, 1, 2'd0, 32'h8000_0000, 32'hFF0F_0000, 0, 0);
    chk("R10 noncontiguous mask", 32'(win_err[8]), 1);
    cfg(9, 1, 2'd0, 32'h8001_0000, 32'hFF00_0000, 0, 0);
    chk("R10 base below mask", 32'(win_err[9]), 1);
    look("R10 rejected miss", 32'h8001_0000, 0, 0);
    cfg(10, 1, 2'd0, 32'h9000_0000, 32'hFFFF_FF80, 0, 0);
    chk("R10 too small", 32'(win_err[10]), 1);

    // R6 priority: window 7 covers window 0
    cfg(7, 1, 2'd0, 32'h1000_0000, 32'hF000_0000, 0, 0);
    look("R6 lowest wins", 32'h10AB_0000, 1, 8'hAB);
    look("R6 only upper", 32'h1812_0000, 1, 8'h81);

    // R11 locked windows
    cfg(1, 1, 2'd1, 32'h4000_0000, 32'hFE00_0000, 8'h11, 0);
    look("R11 cfg ignored", 32'h4000_0040, 1, 8'h5A);
    rmp(3, 0, 8'hFF);
    look("R11 remap ignored", 32'h6000_0000, 1, 8'hA0);

    // R12 disable
    cfg(0, 0, 2'd0, 32'h1000_0000, 32'hFF00_0000, 0, 0);
    look("R12 disabled falls through", 32'h10AB_0000, 1, 8'h0A);
    cfg(2, 0, 2'd1, 32'h5000_0000, 32'hFF00_0000, 0, 0);
    chk("R12 err cleared", 32'(win_err[2]), 0);

    // R7 miss and idle
    look("R7 miss", 32'hF000_0000, 0, 0);
    @(posedge clk); #1;
    chk("R7 idle valid", 32'(res_valid), 0);
    chk("R7 idle hit", 32'(res_hit), 0);

    finish_run();
  end
endmodule